// File: doc/BRIEF.md
# Bounded-Wait Single-Controller I2C Byte Engine

This block moves bytes on a two-wire I2C bus when it is the only controller on that bus. A local agent gives it one command at a time: begin a transfer (START, which also serves as a repeated START), send a byte, receive a byte and answer it with ACK or NACK, or end the transfer (STOP). The block drives each wire only through a pull-low enable. It reads both wires back through a two-stage synchronizer, and it sets the bit timing with a half-period count in system clocks.

Every place where the engine waits for a wire to rise is limited by a programmable cycle count. Slaves may hold SCL low to slow the clock, and the engine waits for them. If a wire stays low beyond the limit, the engine does not stall. It returns one of two fault codes, releases both wires and becomes ready again. This covers a stuck line, a short between the wires, or a slave that never lets go. When a byte is not acknowledged, the engine keeps SCL low so the agent can choose what to send next.

Top module: `i2cm_engine`

## Requirements
- R1: The wire outputs are pull-low enables (1 = wire pulled low, 0 = released). After reset both are 0, `cmdReady` is 1 and `statusValid` is 0.
- R2: The START command (code 0) first releases SDA. It then releases SCL, waits until both wires read high, pulls SDA low, waits one half-period and pulls SCL low. It ends with status code 1 (OK) and leaves both enables at 1.
- R3: The write command (code 1) produces exactly 9 SCL high pulses. The 8 data bits of `txByte` go out most-significant bit first, and SDA is released during the 9th pulse. A low acknowledge gives status 1.
- R4: The read command (code 2) releases SDA for 8 pulses and collects the sampled bits most-significant first into `rxByte`. On the 9th pulse it pulls SDA low if `cmdNack` is 0 and releases it if `cmdNack` is 1.
- R5: A write whose 9th bit reads high ends with status code 2 (NACK). SCL stays pulled low afterwards.
- R6: After releasing SCL, the engine waits until the synchronized SCL reads high and only then counts `halfPeriod` clocks of high time. With no stretching, the high time is between `halfPeriod` and `halfPeriod`+4 clocks.
- R7: In a byte or STOP command, if SCL does not read high within `timeoutLimit` clocks of being released, the command ends with status code 3 (timeout). Both wires are released and the engine returns to ready.
- R8: In START, if SCL does not read high within `timeoutLimit` clocks, or if SDA reads low at the check point, the command ends with status code 4 (bus stuck) and both wires are released.
- R9: The STOP command (code 3) pulls SDA low, releases SCL, waits for SCL high and one half-period, then releases SDA while SCL is high. It ends with status 1 and both wires released.
- R10: Inside byte commands SDA never changes while SCL is high. Outside the cycle that reports a fault, the two enables never change in the same cycle.
- R11: `statusValid` is a single-cycle pulse. `cmdReady` is high only when idle, and a `cmdValid` given while busy is ignored.
- R12: Every command finishes within 10·(2·`halfPeriod` + `timeoutLimit` + 6) clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cmdValid | input | 1 | Command request, taken when `cmdReady` is high |
| cmdCode | input | 2 | 0 START, 1 write, 2 read, 3 STOP |
| txByte | input | 8 | Byte to send for a write |
| cmdNack | input | 1 | For a read: 1 answers with NACK, 0 with ACK |
| halfPeriod | input | PRESC_W | SCL half-period in clocks (at least 1) |
| timeoutLimit | input | TO_W | Wait bound in clocks for a wire to rise (at least 4) |
| cmdReady | output | 1 | Engine idle and able to take a command |
| rxByte | output | 8 | Last byte received |
| statusValid | output | 1 | One-cycle completion pulse |
| statusCode | output | 3 | 1 OK, 2 NACK, 3 timeout, 4 bus stuck |
| sclIn | input | 1 | SCL wire level read back |
| sdaIn | input | 1 | SDA wire level read back |
| sclOe | output | 1 | 1 pulls SCL low |
| sdaOe | output | 1 | 1 pulls SDA low |

## Verification
The bench sweeps every byte value through both the write and the read paths, alternating the ACK/NACK answer on reads. If the bit order were reversed or the shift were off by one, the captured bytes would be wrong. If the pulse count were off, each byte would show something other than 9 rising edges. A stretching slave and a slave that holds SCL past the limit test the two sides of the bounded wait. A design that counted high time from the release instead of from the observed rise would either break the minimum high time or hang. Stuck-low SDA, stuck-low SCL and a shorted pair are each expected to give the right fault code with both wires released, not a silent idle. A command given while the engine is busy must leave no trace on the bus.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

  typedef enum logic [1:0] {
    CMD_START = 2'd0,
    CMD_WRITE = 2'd1,
    CMD_READ  = 2'd2,
    CMD_STOP  = 2'd3
  } cmd_e;

  typedef enum logic [2:0] {
    STAT_NONE    = 3'd0,
    STAT_OK      = 3'd1,
    STAT_NACK    = 3'd2,
    STAT_TIMEOUT = 3'd3,
    STAT_STUCK   = 3'd4
  } stat_e;

  // control-to-datapath strobes, all one cycle wide
  typedef struct packed {
    logic halfLoad;
    logic toClr;
    logic sclLow;
    logic sclRel;
    logic sdaLow;
    logic sdaRel;
    logic sdaBit;
    logic shiftLoad;
    logic loadRead;
    logic shiftStep;
    logic bitClr;
    logic bitInc;
    logic rxLatch;
  } strobe_t;

endpackage

// File: rtl/i2cm_sync.sv
module i2cm_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  // idle bus reads high, so the chain resets to ones
  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) stage[s] <= '1;
          else       stage[s] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) stage[s] <= '1;
          else       stage[s] <= stage[s-1];
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/i2cm_datapath.sv
module i2cm_datapath
  import i2cm_pkg::*;
#(
  parameter int PRESC_W   = 12,
  parameter int TO_W      = 16,
  parameter int DATA_BITS = 8,
  parameter int SYNC_STG  = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              stb,
  input  logic [PRESC_W-1:0]   halfPeriod,
  input  logic [TO_W-1:0]      timeoutLimit,
  input  logic [DATA_BITS-1:0] txByte,
  input  logic                 cmdNack,
  input  logic                 sclIn,
  input  logic                 sdaIn,
  output logic                 halfDone,
  output logic                 toExpired,
  output logic                 sclS,
  output logic                 sdaS,
  output logic                 lastBit,
  output logic                 sclOe,
  output logic                 sdaOe,
  output logic [DATA_BITS-1:0] rxByte
);
  localparam int CNT_W = $clog2(DATA_BITS + 1);

  logic [PRESC_W-1:0]   halfCnt;
  logic [TO_W-1:0]      toCnt;
  logic [DATA_BITS-1:0] shiftReg;
  logic [CNT_W-1:0]     bitCnt;
  logic                 ackRel;
  logic [1:0]           syncOut;

  i2cm_sync #(.W(2), .STAGES(SYNC_STG)) u_sync (
    .clk (clk),
    .rstN(rstN),
    .d   ({sclIn, sdaIn}),
    .q   (syncOut)
  );
  assign sclS = syncOut[1];
  assign sdaS = syncOut[0];

  // half-period down counter
  always_ff @(posedge clk or negedge rstN)
    if (!rstN)              halfCnt <= '0;
    else if (stb.halfLoad)  halfCnt <= (halfPeriod == '0) ? '0 : halfPeriod - PRESC_W'(1);
    else if (halfCnt != '0) halfCnt <= halfCnt - PRESC_W'(1);
  assign halfDone = (halfCnt == '0);

  // wait bound counter, saturates at the limit
  always_ff @(posedge clk or negedge rstN)
    if (!rstN)           toCnt <= '0;
    else if (stb.toClr)  toCnt <= '0;
    else if (!toExpired) toCnt <= toCnt + TO_W'(1);
  assign toExpired = (toCnt >= timeoutLimit);

  // shift register: bit out at the top, sample in at the bottom
  always_ff @(posedge clk or negedge rstN)
    if (!rstN)              shiftReg <= '1;
    else if (stb.shiftLoad) shiftReg <= stb.loadRead ? '1 : txByte;
    else if (stb.shiftStep) shiftReg <= {shiftReg[DATA_BITS-2:0], sdaS};

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)              ackRel <= 1'b1;
    else if (stb.shiftLoad) ackRel <= stb.loadRead ? cmdNack : 1'b1;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)           bitCnt <= '0;
    else if (stb.bitClr) bitCnt <= '0;
    else if (stb.bitInc) bitCnt <= bitCnt + CNT_W'(1);
  assign lastBit = (bitCnt == CNT_W'(DATA_BITS));

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)            rxByte <= '0;
    else if (stb.rxLatch) rxByte <= shiftReg;

  // open-drain enables
  always_ff @(posedge clk or negedge rstN)
    if (!rstN)           sclOe <= 1'b0;
    else if (stb.sclLow) sclOe <= 1'b1;
    else if (stb.sclRel) sclOe <= 1'b0;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)           sdaOe <= 1'b0;
    else if (stb.sdaLow) sdaOe <= 1'b1;
    else if (stb.sdaRel) sdaOe <= 1'b0;
    else if (stb.sdaBit) sdaOe <= lastBit ? !ackRel : !shiftReg[DATA_BITS-1];
endmodule

// File: rtl/i2cm_ctrl.sv
module i2cm_ctrl
  import i2cm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [1:0] cmdCode,
  input  logic       halfDone,
  input  logic       toExpired,
  input  logic       sclS,
  input  logic       sdaS,
  input  logic       lastBit,
  output strobe_t    stb,
  output logic       cmdReady,
  output logic       statusValid,
  output logic [2:0] statusCode
);
  typedef enum logic [3:0] {
    S_IDLE, S_ST_REL, S_ST_SCLHI, S_ST_CHK, S_ST_HOLD,
    S_BIT_SET, S_BIT_LOW, S_BIT_RISE, S_BIT_HIGH,
    S_SP_LOW, S_SP_RISE, S_SP_HIGH, S_SP_END
  } state_e;

  state_e state, nxt;
  logic   readMode, readModeNxt;
  logic   finish;
  stat_e  code, statReg;

  always_comb begin
    stb         = '0;
    nxt         = state;
    finish      = 1'b0;
    code        = STAT_NONE;
    readModeNxt = readMode;
    unique case (state)
      S_IDLE: if (cmdValid) begin
        unique case (cmd_e'(cmdCode))
          CMD_START: begin stb.sdaRel = 1'b1; stb.halfLoad = 1'b1; nxt = S_ST_REL; end
          CMD_WRITE: begin
            stb.shiftLoad = 1'b1; stb.bitClr = 1'b1; readModeNxt = 1'b0; nxt = S_BIT_SET;
          end
          CMD_READ: begin
            stb.shiftLoad = 1'b1; stb.loadRead = 1'b1; stb.bitClr = 1'b1;
            readModeNxt = 1'b1; nxt = S_BIT_SET;
          end
          CMD_STOP: begin stb.sdaLow = 1'b1; stb.halfLoad = 1'b1; nxt = S_SP_LOW; end
        endcase
      end
      S_ST_REL: if (halfDone) begin stb.sclRel = 1'b1; stb.toClr = 1'b1; nxt = S_ST_SCLHI; end
      S_ST_SCLHI:
        if (sclS) begin stb.halfLoad = 1'b1; nxt = S_ST_CHK; end
        else if (toExpired) begin finish = 1'b1; code = STAT_STUCK; end
      S_ST_CHK: if (halfDone) begin
        if (!sdaS || !sclS) begin finish = 1'b1; code = STAT_STUCK; end
        else begin stb.sdaLow = 1'b1; stb.halfLoad = 1'b1; nxt = S_ST_HOLD; end
      end
      S_ST_HOLD: if (halfDone) begin stb.sclLow = 1'b1; finish = 1'b1; code = STAT_OK; end
      S_BIT_SET: begin stb.sdaBit = 1'b1; stb.halfLoad = 1'b1; nxt = S_BIT_LOW; end
      S_BIT_LOW: if (halfDone) begin stb.sclRel = 1'b1; stb.toClr = 1'b1; nxt = S_BIT_RISE; end
      S_BIT_RISE:
        if (sclS) begin stb.halfLoad = 1'b1; nxt = S_BIT_HIGH; end
        else if (toExpired) begin finish = 1'b1; code = STAT_TIMEOUT; end
      S_BIT_HIGH: if (halfDone) begin
        stb.sclLow = 1'b1;
        if (lastBit) begin
          finish = 1'b1;
          if (readMode) begin stb.rxLatch = 1'b1; code = STAT_OK; end
          else code = sdaS ? STAT_NACK : STAT_OK;
        end else begin
          stb.shiftStep = 1'b1; stb.bitInc = 1'b1; nxt = S_BIT_SET;
        end
      end
      S_SP_LOW: if (halfDone) begin stb.sclRel = 1'b1; stb.toClr = 1'b1; nxt = S_SP_RISE; end
      S_SP_RISE:
        if (sclS) begin stb.halfLoad = 1'b1; nxt = S_SP_HIGH; end
        else if (toExpired) begin finish = 1'b1; code = STAT_TIMEOUT; end
      S_SP_HIGH: if (halfDone) begin stb.sdaRel = 1'b1; stb.halfLoad = 1'b1; nxt = S_SP_END; end
      S_SP_END: if (halfDone) begin finish = 1'b1; code = STAT_OK; end
      default: nxt = S_IDLE;
    endcase
    // a fault lets go of both wires
    if (finish && (code == STAT_TIMEOUT || code == STAT_STUCK)) begin
      stb.sclRel = 1'b1;
      stb.sdaRel = 1'b1;
    end
    if (finish) nxt = S_IDLE;
  end

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      state       <= S_IDLE;
      readMode    <= 1'b0;
      statusValid <= 1'b0;
      statReg     <= STAT_NONE;
    end else begin
      state       <= nxt;
      readMode    <= readModeNxt;
      statusValid <= finish;
      if (finish) statReg <= code;
    end

  assign cmdReady   = (state == S_IDLE);
  assign statusCode = statReg;
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
  import i2cm_pkg::*;
#(
  parameter int PRESC_W = 12,
  parameter int TO_W    = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cmdValid,
  input  logic [1:0]         cmdCode,
  input  logic [7:0]         txByte,
  input  logic               cmdNack,
  input  logic [PRESC_W-1:0] halfPeriod,
  input  logic [TO_W-1:0]    timeoutLimit,
  output logic               cmdReady,
  output logic [7:0]         rxByte,
  output logic               statusValid,
  output logic [2:0]         statusCode,
  input  logic               sclIn,
  input  logic               sdaIn,
  output logic               sclOe,
  output logic               sdaOe
);
  strobe_t stb;
  logic    halfDone, toExpired, sclS, sdaS, lastBit;

  i2cm_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdValid   (cmdValid),
    .cmdCode    (cmdCode),
    .halfDone   (halfDone),
    .toExpired  (toExpired),
    .sclS       (sclS),
    .sdaS       (sdaS),
    .lastBit    (lastBit),
    .stb        (stb),
    .cmdReady   (cmdReady),
    .statusValid(statusValid),
    .statusCode (statusCode)
  );

  i2cm_datapath #(.PRESC_W(PRESC_W), .TO_W(TO_W), .DATA_BITS(8), .SYNC_STG(2)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .halfPeriod  (halfPeriod),
    .timeoutLimit(timeoutLimit),
    .txByte      (txByte),
    .cmdNack     (cmdNack),
    .sclIn       (sclIn),
    .sdaIn       (sdaIn),
    .halfDone    (halfDone),
    .toExpired   (toExpired),
    .sclS        (sclS),
    .sdaS        (sdaS),
    .lastBit     (lastBit),
    .sclOe       (sclOe),
    .sdaOe       (sdaOe),
    .rxByte      (rxByte)
  );
endmodule

// File: rtl/i2cm_engine_chk.sv
module i2cm_engine_chk #(
  parameter int PRESC_W = 12,
  parameter int TO_W    = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               cmdValid,
  input logic               cmdReady,
  input logic [PRESC_W-1:0] halfPeriod,
  input logic [TO_W-1:0]    timeoutLimit,
  input logic               statusValid,
  input logic [2:0]         statusCode,
  input logic               sclOe,
  input logic               sdaOe
);
  int busyCnt;
  int busyBound;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)         busyCnt <= 0;
    else if (cmdReady) busyCnt <= 0;
    else               busyCnt <= busyCnt + 1;

  assign busyBound = 10 * (2 * int'(halfPeriod) + int'(timeoutLimit) + 6);

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    statusValid |=> !statusValid);

  assert_idle_holds_R11: assert property (@(posedge clk) disable iff (!rstN)
    (cmdReady && !cmdValid) |=> cmdReady);

  assert_nack_holds_scl_R5: assert property (@(posedge clk) disable iff (!rstN)
    (statusValid && statusCode == 3'd2) |-> sclOe);

  assert_timeout_release_R7: assert property (@(posedge clk) disable iff (!rstN)
    (statusValid && statusCode == 3'd3) |-> (!sclOe && !sdaOe));

  assert_stuck_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    (statusValid && statusCode == 3'd4) |-> (!sclOe && !sdaOe));

  assert_one_wire_moves_R10: assert property (@(posedge clk) disable iff (!rstN)
    !statusValid |-> !(!$stable(sclOe) && !$stable(sdaOe)));

  assert_bounded_busy_R12: assert property (@(posedge clk) disable iff (!rstN)
    busyCnt <= busyBound);
endmodule

bind i2cm_engine i2cm_engine_chk #(.PRESC_W(PRESC_W), .TO_W(TO_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .cmdValid    (cmdValid),
  .cmdReady    (cmdReady),
  .halfPeriod  (halfPeriod),
  .timeoutLimit(timeoutLimit),
  .statusValid (statusValid),
  .statusCode  (statusCode),
  .sclOe       (sclOe),
  .sdaOe       (sdaOe)
);

// File: tb/tb_i2cm_engine.sv
`timescale 1ns/1ps
module tb_i2cm_engine;
  localparam int PW = 12;
  localparam int TW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cmdValid = 1'b0;
  logic [1:0]    cmdCode = 2'd0;
  logic [7:0]    txByte = 8'd0;
  logic          cmdNack = 1'b0;
  logic [PW-1:0] halfPeriod = PW'(4);
  logic [TW-1:0] timeoutLimit = TW'(40);
  logic          cmdReady, statusValid, sclOe, sdaOe;
  logic [7:0]    rxByte;
  logic [2:0]    statusCode;
  logic          sclBus, sdaBus;

  // slave / fault model controls, written only by the stimulus process
  int   stretchLen = 0;
  logic slvAck = 1'b1, slvRead = 1'b0;
  logic [7:0] slvTx = 8'd0;
  logic forceSclLow = 1'b0, forceSdaLow = 1'b0, shorted = 1'b0;

  // slave model state
  logic prevScl = 1'b1, prevSda = 1'b1, skipFall = 1'b0;
  int   bitIdx = 0, stretchCnt = 0, riseCnt = 0, startSeen = 0, stopSeen = 0;
  int   highRun = 0, lastHigh = 0;
  logic [7:0] capByte = 8'd0;
  logic capAck = 1'b1;
  logic slvSdaLow, slvSclLow, sclLowAny, sdaLowAny;

  int nChecks = 0, nFail = 0, cycles = 0;
  bit timedOut = 1'b0;

  always #2 clk = ~clk;

  i2cm_engine #(.PRESC_W(PW), .TO_W(TW)) dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode), .txByte(txByte),
    .cmdNack(cmdNack), .halfPeriod(halfPeriod), .timeoutLimit(timeoutLimit),
    .cmdReady(cmdReady), .rxByte(rxByte), .statusValid(statusValid), .statusCode(statusCode),
    .sclIn(sclBus), .sdaIn(sdaBus), .sclOe(sclOe), .sdaOe(sdaOe)
  );

  assign slvSdaLow = (bitIdx < 8) ? (slvRead && !slvTx[3'(7 - bitIdx)])
                                  : (!slvRead && slvAck);
  assign slvSclLow = (stretchCnt != 0);
  assign sclLowAny = sclOe || slvSclLow || forceSclLow;
  assign sdaLowAny = sdaOe || slvSdaLow || forceSdaLow;
  assign sclBus = !(sclLowAny || (shorted && sdaLowAny));
  assign sdaBus = !(sdaLowAny || (shorted && sclLowAny));

  always @(posedge clk) begin
    cycles <= cycles + 1;
    prevScl <= sclBus;
    prevSda <= sdaBus;
    if (sclBus) highRun <= highRun + 1;
    if (prevScl && sclBus && prevSda && !sdaBus) begin
      startSeen <= startSeen + 1; bitIdx <= 0; skipFall <= 1'b1;
    end
    if (prevScl && sclBus && !prevSda && sdaBus) stopSeen <= stopSeen + 1;
    if (!prevScl && sclBus) begin
      riseCnt <= riseCnt + 1;
      highRun <= 1;
      if (bitIdx < 8) capByte[3'(7 - bitIdx)] <= sdaBus;
      else capAck <= sdaBus;
    end
    if (prevScl && !sclBus) begin
      lastHigh   <= highRun;
      stretchCnt <= stretchLen;
      if (skipFall) skipFall <= 1'b0;
      else bitIdx <= (bitIdx >= 8) ? 0 : bitIdx + 1;
    end else if (stretchCnt > 0) stretchCnt <= stretchCnt - 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doCmd(input logic [1:0] c, input logic [7:0] b, input logic nk,
                       output logic [2:0] code);
    @(negedge clk);
    while (!cmdReady && !timedOut) @(negedge clk);
    cmdValid = 1'b1; cmdCode = c; txByte = b; cmdNack = nk;
    @(negedge clk);
    cmdValid = 1'b0;
    while (!statusValid && !timedOut) @(negedge clk);
    code = statusCode;
    @(negedge clk);
    check(!statusValid, "R11 status pulse one cycle", int'(statusValid), 0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin : watchdog
    while (cycles < 190000) @(posedge clk);
    timedOut = 1'b1;
  end

  initial begin : stim
    logic [2:0] st;
    int r0, s0, p0;
    idle(5);
    // R1 reset state
    check(sclOe == 1'b0 && sdaOe == 1'b0, "R1 enables released in reset", {sclOe, sdaOe}, 0);
    check(cmdReady == 1'b1 && statusValid == 1'b0, "R1 ready, no status in reset",
          {cmdReady, statusValid}, 2);
    rstN = 1'b1;
    idle(5);
    check(sclOe == 1'b0 && sdaOe == 1'b0 && cmdReady, "R1 idle after reset",
          {cmdReady, sclOe, sdaOe}, 4);

    // R2 start
    s0 = startSeen;
    doCmd(2'd0, 8'h00, 1'b0, st);
    check(st == 3'd1, "R2 start status", st, 1);
    check(startSeen == s0 + 1, "R2 start edge on bus", startSeen - s0, 1);
    check(sclOe && sdaOe, "R2 both wires low after start", {sclOe, sdaOe}, 3);

    // R3 write sweep over every byte, R10 no start/stop inside bytes
    s0 = startSeen; p0 = stopSeen;
    slvRead = 1'b0; slvAck = 1'b1;
    for (int v = 0; v < 256; v++) begin
      r0 = riseCnt;
      doCmd(2'd1, 8'(v), 1'b0, st);
      check(st == 3'd1, "R3 write status", st, 1);
      check(capByte == 8'(v), "R3 write bits msb first", capByte, v);
      check(capAck == 1'b0, "R3 ack bit low from slave", capAck, 0);
      check(riseCnt - r0 == 9, "R3 nine pulses", riseCnt - r0, 9);
    end
    check(startSeen == s0 && stopSeen == p0, "R10 SDA steady while SCL high in writes",
          startSeen - s0 + stopSeen - p0, 0);

    // R4 read sweep with alternating answer
    s0 = startSeen; p0 = stopSeen;
    slvRead = 1'b1;
    for (int v = 0; v < 256; v++) begin
      slvTx = 8'(v);
      r0 = riseCnt;
      doCmd(2'd2, 8'h00, v[0], st);
      check(st == 3'd1, "R4 read status", st, 1);
      check(rxByte == 8'(v), "R4 read data", rxByte, v);
      check(capAck == v[0], "R4 answer bit", capAck, v[0]);
      check(riseCnt - r0 == 9, "R4 nine pulses", riseCnt - r0, 9);
    end
    check(startSeen == s0 && stopSeen == p0, "R10 SDA steady while SCL high in reads",
          startSeen - s0 + stopSeen - p0, 0);
    slvRead = 1'b0;

    // R5 nack
    slvAck = 1'b0;
    doCmd(2'd1, 8'h42, 1'b0, st);
    check(st == 3'd2, "R5 nack status", st, 2);
    idle(20);
    check(sclOe == 1'b1, "R5 SCL held after nack", sclOe, 1);
    slvAck = 1'b1;

    // R6 stretching tolerated
    stretchLen = 30; timeoutLimit = TW'(60);
    doCmd(2'd1, 8'h3C, 1'b0, st);
    check(st == 3'd1, "R6 stretched write status", st, 1);
    check(capByte == 8'h3C, "R6 stretched write data", capByte, 8'h3C);
    stretchLen = 0; timeoutLimit = TW'(40);
    idle(40);
    // R6 high time follows the half-period
    doCmd(2'd1, 8'h99, 1'b0, st);
    check(lastHigh >= 4 && lastHigh <= 8, "R6 high time h=4", lastHigh, 4);
    halfPeriod = PW'(10);
    doCmd(2'd1, 8'h66, 1'b0, st);
    check(lastHigh >= 10 && lastHigh <= 14, "R6 high time h=10", lastHigh, 10);
    check(capByte == 8'h66 && st == 3'd1, "R6 data at h=10", capByte, 8'h66);
    halfPeriod = PW'(4);

    // R11 command while busy is ignored
    p0 = stopSeen;
    @(negedge clk);
    cmdValid = 1'b1; cmdCode = 2'd1; txByte = 8'h81;
    @(negedge clk);
    cmdValid = 1'b0;
    idle(6);
    cmdValid = 1'b1; cmdCode = 2'd3;
    @(negedge clk);
    cmdValid = 1'b0;
    while (!statusValid && !timedOut) @(negedge clk);
    check(statusCode == 3'd1, "R11 first command completes", statusCode, 1);
    begin
      int extra = 0;
      for (int i = 0; i < 60; i++) begin
        @(negedge clk);
        if (statusValid) extra++;
      end
      check(extra == 0 && cmdReady, "R11 busy request dropped", extra, 0);
    end
    check(capByte == 8'h81 && stopSeen == p0, "R11 bus unaffected by busy request", capByte, 8'h81);

    // R9 stop
    p0 = stopSeen;
    doCmd(2'd3, 8'h00, 1'b0, st);
    check(st == 3'd1, "R9 stop status", st, 1);
    check(stopSeen == p0 + 1, "R9 stop edge on bus", stopSeen - p0, 1);
    check(!sclOe && !sdaOe && sclBus && sdaBus, "R9 wires free after stop",
          {sclOe, sdaOe, sclBus, sdaBus}, 3);

    // R7 slave holds SCL beyond the limit
    doCmd(2'd0, 8'h00, 1'b0, st);
    stretchLen = 200;
    doCmd(2'd1, 8'hF0, 1'b0, st);
    check(st == 3'd3, "R7 timeout status", st, 3);
    check(!sclOe && !sdaOe && cmdReady, "R7 released and ready", {cmdReady, sclOe, sdaOe}, 4);
    idle(250);
    stretchLen = 0;
    doCmd(2'd3, 8'h00, 1'b0, st);
    check(st == 3'd1, "R9 stop from released bus", st, 1);

    // R8 stuck SDA at start
    forceSdaLow = 1'b1;
    doCmd(2'd0, 8'h00, 1'b0, st);
    check(st == 3'd4, "R8 stuck SDA status", st, 4);
    check(!sclOe && !sdaOe, "R8 released after stuck SDA", {sclOe, sdaOe}, 0);
    forceSdaLow = 1'b0;
    // R8 stuck SCL at start
    forceSclLow = 1'b1;
    doCmd(2'd0, 8'h00, 1'b0, st);
    check(st == 3'd4, "R8 stuck SCL status", st, 4);
    check(!sclOe && !sdaOe, "R8 released after stuck SCL", {sclOe, sdaOe}, 0);
    forceSclLow = 1'b0;
    idle(10);

    // R7 shorted wires: a low data bit keeps SCL low
    shorted = 1'b1;
    doCmd(2'd0, 8'h00, 1'b0, st);
    doCmd(2'd1, 8'h00, 1'b0, st);
    check(st == 3'd3, "R7 shorted wires timeout", st, 3);
    check(!sclOe && !sdaOe && cmdReady, "R7 released after short", {cmdReady, sclOe, sdaOe}, 4);
    shorted = 1'b0;
    idle(10);

    // recovery after faults
    doCmd(2'd0, 8'h00, 1'b0, st);
    check(st == 3'd1, "R2 start after faults", st, 1);
    doCmd(2'd1, 8'hA7, 1'b0, st);
    check(st == 3'd1 && capByte == 8'hA7, "R3 write after faults", capByte, 8'hA7);
    doCmd(2'd3, 8'h00, 1'b0, st);
    check(st == 3'd1, "R9 final stop", st, 1);

    if (timedOut) check(1'b0, "watchdog expired", cycles, 0);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end
endmodule